// File: doc/BRIEF.md
# Thread Block Distributor

This block hands the thread blocks of a launched kernel to a set of streaming multiprocessors. A kernel is presented as a block count and a per-block thread count. After it accepts a launch, the distributor gives out block indices in strict increasing order, one offer at a time. Each offer goes to a multiprocessor whose free thread capacity still has room for one more block. A multiprocessor can hold several blocks at once. Warp scheduling inside each multiprocessor belongs to the multiprocessor and is not part of this block.

Capacity is counted in whole warps of 32 threads. Each multiprocessor owns a credit counter that starts full. A dispatch handshake takes one block's warps from that counter. A completion pulse from the multiprocessor gives the same amount back, and the freed room can at once receive further blocks. When every block has been dispatched and has reported completion, the block raises a one-cycle kernel-done pulse and returns to idle. While a kernel is in progress, a new launch is refused.

Top module: `thread_block_distributor`

## Requirements
- R1: `launch_ready` is high exactly while the distributor is idle. A launch presented while `launch_ready` is low has no effect: the running kernel's dispatch order, block count and completion are unchanged.
- R2: A block needs ceil(`launch_threads`/32) warps of capacity. A thread count of zero is treated as one warp.
- R3: Each multiprocessor holds `CAP_THREADS`/32 warps of capacity, which is full after reset. A block is offered to a multiprocessor only if that multiprocessor's free warps are at least the block's warp need, so resident warps never exceed the capacity.
- R4: Block indices are dispatched as 0, 1, …, N-1, each exactly once, where N is `launch_blocks`.
- R5: A new offer goes to the first multiprocessor, scanning upward with wrap-around from the one after the last multiprocessor granted, whose free warps fit the block. The scan starts at multiprocessor 0 after reset, and the scan position carries over from one kernel to the next.
- R6: At most one `disp_valid` bit is high at a time. Once raised, it stays high with an unchanged `disp_block_idx` slice until the matching `disp_ready` is seen high at a clock edge. The offer then drops for at least one cycle.
- R7: A pulse on `sm_done[s]` returns one block's warps to multiprocessor s. Several blocks may be resident on one multiprocessor.
- R8: `kernel_done` is high for exactly one cycle, in the cycle after the edge that records the last completion. A kernel with zero blocks raises it two cycles after the launch is accepted.
- R9: After reset, `launch_ready` is 1, `disp_valid` is all zero and `kernel_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Kernel launch request |
| launch_ready | output | 1 | High while idle; a launch is taken when both are high |
| launch_blocks | input | BIDX_W | Number of thread blocks in the kernel |
| launch_threads | input | THR_W | Threads per block |
| disp_valid | output | NUM_SM | Per-multiprocessor block offer |
| disp_ready | input | NUM_SM | Per-multiprocessor acceptance |
| disp_block_idx | output | NUM_SM*BIDX_W | Block index, slice s for multiprocessor s |
| sm_done | input | NUM_SM | One pulse per completed block, per multiprocessor |
| kernel_done | output | 1 | One-cycle pulse when the kernel has finished |

## Verification
The bench targets the following cases:
- Blocks that use a full multiprocessor. With these, a wrong fit test would place two blocks on one multiprocessor and break the capacity model.
- Thread counts of 32, 33 and zero. A rounding slip would change how many blocks fit, so the round-robin choice would no longer match the model.
- A completion and a grant on the same multiprocessor in the same cycle. A design that loses one of the two updates would leak or create credit.
- A zero-block kernel and a launch held high during a busy kernel. A design that accepts the late launch would restart the indices or miss the kernel-done pulse.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

    typedef enum logic [1:0] {
        TBD_IDLE = 2'd0,
        TBD_RUN  = 2'd1,
        TBD_FIN  = 2'd2
    } tbd_state_e;

    localparam int WARP_SIZE = 32;

    function automatic int tbd_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tbd_warp_round.sv
module tbd_warp_round
    import tbd_pkg::*;
#(
    parameter int THR_W = 11,
    parameter int CW    = 7
) (
    input  logic [THR_W-1:0] threads,
    output logic [CW-1:0]    warps
);
    localparam int PW     = THR_W + 1;
    localparam int LOG_WS = $clog2(WARP_SIZE);

    logic [PW-1:0] padded;

    always_comb begin
        padded = {1'b0, threads} + PW'(WARP_SIZE - 1);
        warps  = CW'(padded >> LOG_WS);
        if (threads == '0) begin
            warps = CW'(1);
        end
    end
endmodule

// File: rtl/tbd_sm_credit.sv
module tbd_sm_credit #(
    parameter int CW        = 7,
    parameter int CAP_WARPS = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    input  logic [CW-1:0] need,
    output logic [CW-1:0] free,
    output logic          fits
);
    logic [CW-1:0] free_d, free_q;

    always_comb begin
        free_d = free_q;
        if (take) begin
            free_d = free_d - need;
        end
        if (give) begin
            free_d = free_d + need;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= CW'(CAP_WARPS);
        end else begin
            free_q <= free_d;
        end
    end

    assign free = free_q;
    assign fits = (free_q >= need);
endmodule

// File: rtl/tbd_rr_pick.sv
module tbd_rr_pick #(
    parameter int N  = 16,
    parameter int SW = 4
) (
    input  logic [N-1:0]  req,
    input  logic [SW-1:0] ptr,
    output logic          found,
    output logic [SW-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N) begin
                idx = idx - N;
            end
            if (req[idx]) begin
                found = 1'b1;
                pick  = SW'(idx);
            end
        end
    end
endmodule

// File: rtl/thread_block_distributor.sv
module thread_block_distributor
    import tbd_pkg::*;
#(
    parameter int NUM_SM      = 16,
    parameter int CAP_THREADS = 1536,
    parameter int BIDX_W      = 16,
    parameter int THR_W       = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch_valid,
    output logic                     launch_ready,
    input  logic [BIDX_W-1:0]        launch_blocks,
    input  logic [THR_W-1:0]         launch_threads,
    output logic [NUM_SM-1:0]        disp_valid,
    input  logic [NUM_SM-1:0]        disp_ready,
    output logic [NUM_SM*BIDX_W-1:0] disp_block_idx,
    input  logic [NUM_SM-1:0]        sm_done,
    output logic                     kernel_done
);
    localparam int CAP_WARPS = CAP_THREADS / WARP_SIZE;
    localparam int SW        = (NUM_SM > 1) ? $clog2(NUM_SM) : 1;
    localparam int CW        = tbd_max(THR_W + 1 - $clog2(WARP_SIZE),
                                       $clog2(CAP_WARPS + 1));

    typedef struct packed {
        tbd_state_e        st;
        logic [BIDX_W-1:0] total;
        logic [BIDX_W-1:0] next_idx;
        logic [BIDX_W-1:0] done_cnt;
        logic [CW-1:0]     wpb;
        logic              offer_vld;
        logic [SW-1:0]     offer_sm;
        logic [SW-1:0]     rr_ptr;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [CW-1:0]        launch_warps;
    logic [NUM_SM-1:0]    sm_fits;
    logic [NUM_SM-1:0]    sm_take;
    logic [NUM_SM-1:0]    sm_give;
    logic [NUM_SM*CW-1:0] sm_free;
    logic [CW-1:0]        blk_warps;
    logic                 pick_found;
    logic [SW-1:0]        pick_sm;
    logic                 hs;
    logic [BIDX_W-1:0]    done_inc;

    tbd_warp_round #(.THR_W(THR_W), .CW(CW)) u_round (
        .threads (launch_threads),
        .warps   (launch_warps)
    );

    tbd_rr_pick #(.N(NUM_SM), .SW(SW)) u_pick (
        .req   (sm_fits),
        .ptr   (r_q.rr_ptr),
        .found (pick_found),
        .pick  (pick_sm)
    );

    generate
        for (genvar s = 0; s < NUM_SM; s++) begin : g_sm
            assign sm_take[s] = hs && (r_q.offer_sm == SW'(s));
            assign sm_give[s] = sm_done[s] && (r_q.st == TBD_RUN);
            assign disp_valid[s] = r_q.offer_vld && (r_q.offer_sm == SW'(s));
            assign disp_block_idx[s*BIDX_W +: BIDX_W] = r_q.next_idx;

            tbd_sm_credit #(.CW(CW), .CAP_WARPS(CAP_WARPS)) u_credit (
                .clk   (clk),
                .rst_n (rst_n),
                .take  (sm_take[s]),
                .give  (sm_give[s]),
                .need  (r_q.wpb),
                .free  (sm_free[s*CW +: CW]),
                .fits  (sm_fits[s])
            );
        end
    endgenerate

    assign blk_warps    = r_q.wpb;
    assign launch_ready = (r_q.st == TBD_IDLE);
    assign kernel_done  = (r_q.st == TBD_FIN);

    always_comb begin
        hs       = r_q.offer_vld && disp_ready[r_q.offer_sm];
        done_inc = '0;
        for (int s = 0; s < NUM_SM; s++) begin
            done_inc = done_inc + BIDX_W'(sm_give[s]);
        end

        r_d = r_q;
        unique case (r_q.st)
            TBD_IDLE: begin
                if (launch_valid) begin
                    r_d.st        = TBD_RUN;
                    r_d.total     = launch_blocks;
                    r_d.next_idx  = '0;
                    r_d.done_cnt  = '0;
                    r_d.wpb       = launch_warps;
                    r_d.offer_vld = 1'b0;
                end
            end
            TBD_RUN: begin
                r_d.done_cnt = r_q.done_cnt + done_inc;
                if (hs) begin
                    r_d.offer_vld = 1'b0;
                    r_d.next_idx  = r_q.next_idx + 1'b1;
                    r_d.rr_ptr    = (r_q.offer_sm == SW'(NUM_SM - 1)) ?
                                    '0 : r_q.offer_sm + 1'b1;
                end else if (!r_q.offer_vld && (r_q.next_idx < r_q.total)
                             && pick_found) begin
                    r_d.offer_vld = 1'b1;
                    r_d.offer_sm  = pick_sm;
                end
                if (r_d.done_cnt == r_q.total) begin
                    r_d.st = TBD_FIN;
                end
            end
            TBD_FIN: begin
                r_d.st = TBD_IDLE;
            end
            default: begin
                r_d.st = TBD_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: TBD_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/tbd_checker.sv
module tbd_checker #(
    parameter int NUM_SM    = 16,
    parameter int BIDX_W    = 16,
    parameter int CW        = 7,
    parameter int CAP_WARPS = 48
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     launch_valid,
    input logic                     launch_ready,
    input logic [NUM_SM-1:0]        disp_valid,
    input logic [NUM_SM-1:0]        disp_ready,
    input logic [NUM_SM*BIDX_W-1:0] disp_block_idx,
    input logic                     kernel_done,
    input logic [NUM_SM*CW-1:0]     sm_free,
    input logic [CW-1:0]            blk_warps
);
    assert_onehot_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_valid));

    assert_launch_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_ready) |=> !launch_ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_done |=> !kernel_done);

    assert_done_not_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_done |-> !launch_ready);

    generate
        for (genvar s = 0; s < NUM_SM; s++) begin : g_chk
            assert_hold_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (disp_valid[s] && !disp_ready[s]) |=>
                    (disp_valid[s] && $stable(disp_block_idx[s*BIDX_W +: BIDX_W])));

            assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
                sm_free[s*CW +: CW] <= CW'(CAP_WARPS));

            assert_offer_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
                disp_valid[s] |-> (sm_free[s*CW +: CW] >= blk_warps));
        end
    endgenerate
endmodule

bind thread_block_distributor tbd_checker #(
    .NUM_SM    (NUM_SM),
    .BIDX_W    (BIDX_W),
    .CW        (CW),
    .CAP_WARPS (CAP_WARPS)
) u_tbd_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch_valid   (launch_valid),
    .launch_ready   (launch_ready),
    .disp_valid     (disp_valid),
    .disp_ready     (disp_ready),
    .disp_block_idx (disp_block_idx),
    .kernel_done    (kernel_done),
    .sm_free        (sm_free),
    .blk_warps      (blk_warps)
);

// File: tb/tb_thread_block_distributor.sv
module tb_thread_block_distributor;
    localparam int CLK_PERIOD = 10;
    localparam int NS    = 4;
    localparam int CAPT  = 1536;
    localparam int CAPW  = CAPT / 32;
    localparam int BW    = 16;
    localparam int TW    = 11;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              launch_valid;
    logic              launch_ready;
    logic [BW-1:0]     launch_blocks;
    logic [TW-1:0]     launch_threads;
    logic [NS-1:0]     disp_valid;
    logic [NS-1:0]     disp_ready;
    logic [NS*BW-1:0]  disp_block_idx;
    logic [NS-1:0]     sm_done;
    logic              kernel_done;

    thread_block_distributor #(
        .NUM_SM(NS), .CAP_THREADS(CAPT), .BIDX_W(BW), .THR_W(TW)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_ready(launch_ready),
        .launch_blocks(launch_blocks), .launch_threads(launch_threads),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_block_idx(disp_block_idx), .sm_done(sm_done),
        .kernel_done(kernel_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;

    int mfree [NS];
    int snap  [NS];
    int life  [NS][64];
    int nres  [NS];
    int rr, wpb, exp_idx, total, completed, due;
    logic [NS-1:0] prev_valid, prev_ready;
    logic [BW-1:0] prev_idx [NS];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int warps_of(input int t);
        return (t == 0) ? 1 : (t + 31) / 32;
    endfunction

    function automatic int pick_from(input int r);
        for (int k = 0; k < NS; k++) begin
            int s;
            s = (r + k) % NS;
            if (snap[s] >= wpb) return s;
        end
        return -1;
    endfunction

    task automatic step(input bit junk, output bit finished);
        logic [NS-1:0] vld, rdy, dn;
        finished = 1'b0;
        @(negedge clk);
        vld = disp_valid;
        chk($countones(vld) <= 1, "R6 onehot", $countones(vld), 1);
        chk(launch_ready == 1'b0, "R1 busy ready", launch_ready, 0);
        for (int s = 0; s < NS; s++) begin
            if (prev_valid[s] && !prev_ready[s]) begin
                chk(vld[s] && disp_block_idx[s*BW +: BW] == prev_idx[s], "R6 hold",
                    int'(disp_block_idx[s*BW +: BW]), int'(prev_idx[s]));
            end
        end
        if (prev_valid == '0 && vld != '0) begin
            int got, exp;
            got = -1;
            for (int s = 0; s < NS; s++) if (vld[s]) got = s;
            exp = pick_from(rr);
            chk(got == exp, "R5 rr choice", got, exp);
        end
        if (due > 0) begin
            due--;
            if (due == 0) begin
                chk(kernel_done == 1'b1, "R8 done pulse", kernel_done, 1);
                finished = 1'b1;
            end else begin
                chk(kernel_done == 1'b0, "R8 early done", kernel_done, 0);
            end
        end else begin
            chk(kernel_done == 1'b0, "R8 spurious done", kernel_done, 0);
        end
        for (int s = 0; s < NS; s++) snap[s] = mfree[s];
        if (finished) begin
            disp_ready   = '0;
            sm_done      = '0;
            launch_valid = 1'b0;
            return;
        end
        dn = '0;
        for (int s = 0; s < NS; s++) begin
            int hit;
            hit = -1;
            for (int j = 0; j < nres[s]; j++) begin
                life[s][j]--;
                if (life[s][j] <= 0 && hit < 0) hit = j;
            end
            if (hit >= 0) begin
                life[s][hit] = life[s][nres[s]-1];
                nres[s]--;
                dn[s] = 1'b1;
                mfree[s] += wpb; // R7 credit return
                completed++;
            end
        end
        if (dn != '0 && completed == total) due = 1;
        for (int s = 0; s < NS; s++) rdy[s] = ($urandom % 4) != 0;
        for (int s = 0; s < NS; s++) begin
            if (vld[s] && rdy[s]) begin
                chk(int'(disp_block_idx[s*BW +: BW]) == exp_idx, "R4 order",
                    int'(disp_block_idx[s*BW +: BW]), exp_idx);
                chk(snap[s] >= wpb, "R3 fit", snap[s], wpb);
                mfree[s] -= wpb;
                life[s][nres[s]] = 1 + int'($urandom % 12);
                nres[s]++;
                exp_idx++;
                rr = (s + 1) % NS;
            end
        end
        prev_valid = vld;
        prev_ready = rdy;
        for (int s = 0; s < NS; s++) prev_idx[s] = disp_block_idx[s*BW +: BW];
        disp_ready = rdy;
        sm_done    = dn;
        if (junk) begin
            launch_valid   = 1'b1; // R1: must be ignored while busy
            launch_blocks  = 16'd3;
            launch_threads = 11'd64;
        end else begin
            launch_valid = 1'b0;
        end
    endtask

    task automatic run_kernel(input int blocks, input int threads, input bit junk);
        bit fin;
        @(negedge clk);
        chk(launch_ready == 1'b1, "R1 idle ready", launch_ready, 1);
        launch_valid   = 1'b1;
        launch_blocks  = BW'(blocks);
        launch_threads = TW'(threads);
        total     = blocks;
        wpb       = warps_of(threads); // R2 rounding
        exp_idx   = 0;
        completed = 0;
        due       = (blocks == 0) ? 2 : 0;
        prev_valid = '0;
        prev_ready = '0;
        fin = 1'b0;
        for (int i = 0; i < 20000 && !fin; i++) step(junk, fin);
        chk(fin, "R8 kernel finished", fin, 1);
        chk(exp_idx == total, "R4 all dispatched", exp_idx, total);
        chk(completed == total, "R7 all completed", completed, total);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        launch_valid = 1'b0;
        launch_blocks = '0;
        launch_threads = '0;
        disp_ready = '0;
        sm_done = '0;
        rr = 0;
        for (int s = 0; s < NS; s++) begin
            mfree[s] = CAPW;
            snap[s]  = CAPW;
            nres[s]  = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(launch_ready == 1'b1, "R9 reset ready", launch_ready, 1);
        chk(disp_valid == '0, "R9 reset valid", disp_valid, 0);
        chk(kernel_done == 1'b0, "R9 reset done", kernel_done, 0);

        run_kernel(0, 64, 1'b0);      // R8 empty kernel
        run_kernel(10, 1536, 1'b0);   // R3 full-SM blocks
        run_kernel(12, 33, 1'b0);     // R2 round up
        run_kernel(20, 32, 1'b0);     // R2 exact multiple
        run_kernel(30, 0, 1'b0);      // R2 zero threads
        run_kernel(15, 700, 1'b1);    // R1 launch held while busy
        run_kernel(60, 1, 1'b0);      // R7 many residents
        for (int k = 0; k < 25; k++) begin
            run_kernel(int'($urandom % 40), 1 + int'($urandom % 1536), k[0]);
        end
        @(negedge clk);
        chk(launch_ready == 1'b1, "R1 idle after done", launch_ready, 1);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule